// File: doc/BRIEF.md
# Video Stream Control Synchronizer

This block sits inline on a packetized video stream that uses valid/ready handshaking with start-of-packet and end-of-packet markers. Every beat goes from input to output unchanged. The block also parses the stream and looks for two kinds of trigger event:

- the header beat of a video packet;
- a control packet whose frame size differs from the last one that passed.

When a trigger fires and triggering is enabled, the block holds the stream in that same cycle. It then uses a memory-mapped master port to send a programmed list of address/data writes to cores further down the path. When the list is done, it lets the held beat through and raises a sticky interrupt. This ordering means downstream cores hold their new settings before the packet those settings apply to reaches them.

Software uses a small memory-mapped slave port to do three things:

- load the write list;
- set how many entries of the list are used;
- enable triggering and clear the interrupt.

Control follows a three-state machine:

- `SQ_IDLE` watches the stream.
  - On a trigger it moves to `SQ_ISSUE`.
  - If the entry count is zero it moves straight to `SQ_DONE`.
- `SQ_ISSUE` drives one write at a time.
  - It steps to the next entry when the slave drops waitrequest.
  - It moves to `SQ_DONE` once the last entry is accepted.
- `SQ_DONE` lets the held beat through without re-checking it for a trigger. It returns to `SQ_IDLE` when that beat transfers.

Top module: `ctrlsync_top`

## Requirements
- R1: When no hold is active, `out_valid`, `out_data`, `out_sop` and `out_eop` equal `in_valid`, `in_data`, `in_sop` and `in_eop`, and `in_ready` equals `out_ready`. After reset no hold is active and `irq` is 0.
- R2: The packet type is bits [3:0] of the start-of-packet beat. A start-of-packet beat of type 0 is a video trigger. The hold shows in that same cycle: `in_ready` and `out_valid` are both 0.
- R3: A packet of type 15 is a control packet. The beat after its header carries the width in bits [15:0], and the beat after that carries the height. If either value differs from the stored pair, the stream is held at the height beat. The stored pair is loaded when the height beat transfers and is zero after reset.
- R4: While the enable bit is 0, no trigger is taken and the stream passes through as in R1.
- R5: While held, the block sends entries 0 to count-1 in ascending order, one at a time. `m_write`, `m_address` and `m_writedata` stay steady while `m_waitrequest` is 1, and the stream stays held.
- R6: In the cycle after the last write is accepted, the held beat is offered again on the output and is not treated as a trigger a second time.
- R7: When a write list finishes, status bit 0 and `irq` are set to 1. They stay at 1 until software writes 1 to bit 0 of offset 2. Writing 0 to that bit leaves them unchanged.
- R8: With a count of 0, a trigger holds the stream only in the cycle it is seen. The beat is offered in the next cycle, with no master write and with `irq` set.
- R9: Register map, read back combinationally on `s_readdata`:
  - offset 0: bit 0 is the enable bit;
  - offset 1: the count, where values above ENTRIES are stored as ENTRIES;
  - offset 2: the status;
  - offset 4+2i: the target address of entry i;
  - offset 5+2i: the data of entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | SD_W | Stream input data |
| in_valid | input | 1 | Stream input valid |
| in_sop | input | 1 | Stream input start of packet |
| in_eop | input | 1 | Stream input end of packet |
| in_ready | output | 1 | Stream input ready |
| out_data | output | SD_W | Stream output data |
| out_valid | output | 1 | Stream output valid |
| out_sop | output | 1 | Stream output start of packet |
| out_eop | output | 1 | Stream output end of packet |
| out_ready | input | 1 | Stream output ready |
| m_address | output | REG_W | Master write address |
| m_writedata | output | REG_W | Master write data |
| m_write | output | 1 | Master write strobe |
| m_waitrequest | input | 1 | Master wait request from the target |
| s_address | input | SA_W | Slave register word offset |
| s_write | input | 1 | Slave write strobe |
| s_writedata | input | REG_W | Slave write data |
| s_readdata | output | REG_W | Slave read data for `s_address` |
| irq | output | 1 | Sticky writes-complete interrupt |

## Verification
The bench builds the block with ENTRIES=4 and otherwise default widths. With ENTRIES=4, writing 12 to the count register shows the clamp, and a three-entry list runs close to the full table. Stretched waitrequest phases show that each write stays steady while it waits. Control packets are sent with the same size, a new width, a new height, and with the enable bit off. Together these cover every path through the comparison and the update of the stored size.

// File: rtl/ctrlsync_pkg.sv
package ctrlsync_pkg;
    localparam logic [3:0] PKT_VIDEO = 4'h0;
    localparam logic [3:0] PKT_CTRL  = 4'hF;

    localparam int OFF_CTRL   = 0;
    localparam int OFF_COUNT  = 1;
    localparam int OFF_STATUS = 2;
    localparam int OFF_TABLE  = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_DONE
    } seq_state_t;
endpackage

// File: rtl/ctrlsync_regs.sv
module ctrlsync_regs
    import ctrlsync_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 32,
    parameter int SA_W    = 5,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SA_W-1:0]  s_address,
    input  logic             s_write,
    input  logic [REG_W-1:0] s_writedata,
    output logic [REG_W-1:0] s_readdata,
    output logic             go,
    output logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] ent_addr,
    output logic [REG_W-1:0] ent_data,
    input  logic             done_pulse,
    output logic             irq
);
    logic [REG_W-1:0] ent_a [ENTRIES];
    logic [REG_W-1:0] ent_d [ENTRIES];
    logic [SA_W-1:0]  rel;
    logic [SA_W-2:0]  kw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go    <= 1'b0;
            count <= '0;
            irq   <= 1'b0;
        end else begin
            if (s_write && s_address == SA_W'(OFF_CTRL)) go <= s_writedata[0];
            if (s_write && s_address == SA_W'(OFF_COUNT)) begin
                if (s_writedata > REG_W'(ENTRIES)) count <= CNT_W'(ENTRIES);
                else                               count <= s_writedata[CNT_W-1:0];
            end
            if (done_pulse)
                irq <= 1'b1;
            else if (s_write && s_address == SA_W'(OFF_STATUS) && s_writedata[0])
                irq <= 1'b0;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_a[i] <= '0;
                ent_d[i] <= '0;
            end else if (s_write && s_address == SA_W'(OFF_TABLE + 2*i)) begin
                ent_a[i] <= s_writedata;
            end else if (s_write && s_address == SA_W'(OFF_TABLE + 2*i + 1)) begin
                ent_d[i] <= s_writedata;
            end
        end
    end

    assign ent_addr = ent_a[idx];
    assign ent_data = ent_d[idx];

    always_comb begin
        s_readdata = '0;
        rel = s_address - SA_W'(OFF_TABLE);
        kw  = rel[SA_W-1:1];
        if (s_address == SA_W'(OFF_CTRL))
            s_readdata[0] = go;
        else if (s_address == SA_W'(OFF_COUNT))
            s_readdata = REG_W'(count);
        else if (s_address == SA_W'(OFF_STATUS))
            s_readdata[0] = irq;
        else if (s_address >= SA_W'(OFF_TABLE) && kw < (SA_W-1)'(ENTRIES))
            s_readdata = rel[0] ? ent_d[kw[IDX_W-1:0]] : ent_a[kw[IDX_W-1:0]];
    end

    // R7: a finished list always leaves the interrupt set
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq);
endmodule

// File: rtl/ctrlsync_watch.sv
module ctrlsync_watch
    import ctrlsync_pkg::*;
#(
    parameter int SD_W    = 16,
    parameter int FIELD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SD_W-1:0] in_data,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            xfer,
    output logic            raw_trig
);
    logic [3:0]         ptype;
    logic [1:0]         beat;
    logic [FIELD_W-1:0] cur_w, stored_w, stored_h;
    logic [FIELD_W-1:0] field;

    assign field = in_data[FIELD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptype    <= PKT_VIDEO;
            beat     <= '0;
            cur_w    <= '0;
            stored_w <= '0;
            stored_h <= '0;
        end else if (xfer) begin
            if (in_sop) begin
                ptype <= in_data[3:0];
                beat  <= 2'd1;
            end else begin
                if (beat != 2'd3) beat <= beat + 2'd1;
                if (ptype == PKT_CTRL && beat == 2'd1) cur_w <= field;
                if (ptype == PKT_CTRL && beat == 2'd2) begin
                    stored_w <= cur_w;
                    stored_h <= field;
                end
            end
        end
    end

    always_comb begin
        raw_trig = 1'b0;
        if (in_valid) begin
            if (in_sop)
                raw_trig = (in_data[3:0] == PKT_VIDEO);
            else if (ptype == PKT_CTRL && beat == 2'd2)
                raw_trig = (cur_w != stored_w) || (field != stored_h);
        end
    end

    // R3: the stored frame size moves only when a beat is taken
    assert_size_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_h != $past(stored_h) || stored_w != $past(stored_w)) |-> $past(xfer));
endmodule

// File: rtl/ctrlsync_seq.sv
module ctrlsync_seq
    import ctrlsync_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] count,
    input  logic             xfer,
    input  logic             m_waitrequest,
    output logic [IDX_W-1:0] idx,
    output logic             m_write,
    output logic             hold,
    output logic             done_pulse
);
    seq_state_t state, nxt;
    logic       last;

    assign last = (CNT_W'(idx) + CNT_W'(1)) == count;

    always_comb begin
        nxt        = state;
        done_pulse = 1'b0;
        unique case (state)
            SQ_IDLE: if (trig) begin
                if (count == '0) begin
                    nxt        = SQ_DONE;
                    done_pulse = 1'b1;
                end else begin
                    nxt = SQ_ISSUE;
                end
            end
            SQ_ISSUE: if (!m_waitrequest && last) begin
                nxt        = SQ_DONE;
                done_pulse = 1'b1;
            end
            SQ_DONE: if (xfer) nxt = SQ_IDLE;
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            if (state == SQ_IDLE)
                idx <= '0;
            else if (state == SQ_ISSUE && !m_waitrequest && !last)
                idx <= idx + IDX_W'(1);
        end
    end

    always_comb begin
        m_write = (state == SQ_ISSUE);
        hold    = (state == SQ_ISSUE) || (state == SQ_IDLE && trig);
    end

    // R5: a waiting write keeps its entry
    assert_write_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(idx)));
    // R5: every list starts at entry 0
    assert_first_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_write) |-> idx == '0);
endmodule

// File: rtl/ctrlsync_top.sv
module ctrlsync_top
    import ctrlsync_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SD_W    = 16,
    parameter int FIELD_W = 16,
    parameter int REG_W   = 32,
    localparam int SA_W   = $clog2(OFF_TABLE + 2*ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SD_W-1:0]  in_data,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    output logic [SD_W-1:0]  out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    input  logic             out_ready,
    output logic [REG_W-1:0] m_address,
    output logic [REG_W-1:0] m_writedata,
    output logic             m_write,
    input  logic             m_waitrequest,
    input  logic [SA_W-1:0]  s_address,
    input  logic             s_write,
    input  logic [REG_W-1:0] s_writedata,
    output logic [REG_W-1:0] s_readdata,
    output logic             irq
);
    logic             go, raw_trig, hold, xfer, done_pulse;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] idx;

    assign in_ready  = out_ready && !hold;
    assign out_valid = in_valid && !hold;
    assign out_data  = in_data;
    assign out_sop   = in_sop;
    assign out_eop   = in_eop;
    assign xfer      = in_valid && in_ready;

    ctrlsync_watch #(.SD_W(SD_W), .FIELD_W(FIELD_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .xfer(xfer), .raw_trig(raw_trig)
    );

    ctrlsync_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(raw_trig && go), .count(count),
        .xfer(xfer), .m_waitrequest(m_waitrequest), .idx(idx),
        .m_write(m_write), .hold(hold), .done_pulse(done_pulse)
    );

    ctrlsync_regs #(
        .ENTRIES(ENTRIES), .REG_W(REG_W), .SA_W(SA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .s_address(s_address), .s_write(s_write),
        .s_writedata(s_writedata), .s_readdata(s_readdata), .go(go), .count(count),
        .idx(idx), .ent_addr(m_address), .ent_data(m_writedata),
        .done_pulse(done_pulse), .irq(irq)
    );

    // R2: while a write is on the master port the stream is frozen
    assert_stall_during_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> (!in_ready && !out_valid));
    // R6: when the list ends the held beat is offered again
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_write) |-> (!in_valid || out_valid));
endmodule

// File: tb/tb_ctrlsync_top.sv
module tb_ctrlsync_top;
    localparam int ENTRIES = 4;
    localparam int SA_W    = $clog2(4 + 2*ENTRIES);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
    logic        in_ready, out_valid, out_sop, out_eop;
    logic [15:0] out_data;
    logic [31:0] m_address, m_writedata, s_readdata;
    logic        m_write, irq;
    logic        m_waitrequest = 1'b0;
    logic [SA_W-1:0] s_address = '0;
    logic        s_write = 1'b0;
    logic [31:0] s_writedata = '0;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // {sop, eop, out_ready, data}
    localparam logic [18:0] VEC [8] = '{
        19'h50000, 19'h11111, 19'h02222, 19'h33333,
        19'h40000, 19'h50000, 19'h3BEEF, 19'h700A5
    };

    always #4 clk = ~clk;

    ctrlsync_top #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_ready(out_ready), .m_address(m_address), .m_writedata(m_writedata),
        .m_write(m_write), .m_waitrequest(m_waitrequest), .s_address(s_address),
        .s_write(s_write), .s_writedata(s_writedata), .s_readdata(s_readdata),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        s_address = SA_W'(a); s_writedata = d; s_write = 1'b1;
        @(posedge clk); #1;
        s_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        s_address = SA_W'(a);
        #1;
        chk(tag, s_readdata, exp);
    endtask

    task automatic beat(input logic sop, input logic eop, input logic [15:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        @(negedge clk);
    endtask

    task automatic send_ctrl(input logic [15:0] w, input logic [15:0] h, input bit stall);
        beat(1'b1, 1'b0, 16'h000F);
        chk("R3 header passes", 32'(in_ready), 32'd1);
        beat(1'b0, 1'b0, w);
        chk("R3 width passes", 32'(in_ready), 32'd1);
        beat(1'b0, 1'b1, h);
        chk("R3 height beat hold", 32'(in_ready), stall ? 32'd0 : 32'd1);
        if (stall) begin
            @(posedge clk); #1;
            @(negedge clk);
            chk("R5 write issued", 32'(m_write), 32'd1);
            @(posedge clk); #1;
            @(negedge clk);
            chk("R6 height beat released", 32'(out_valid), 32'd1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_ready", 32'(in_ready), 32'd1);
        chk("R1 reset out_valid", 32'(out_valid), 32'd0);
        chk("R1 reset irq", 32'(irq), 32'd0);
        chk("R1 reset m_write", 32'(m_write), 32'd0);

        // table walk with triggering disabled
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            {in_sop, in_eop, out_ready, in_data} = VEC[i];
            in_valid = 1'b1;
            @(negedge clk);
            chk("R1 out_data", 32'(out_data), 32'(VEC[i][15:0]));
            chk("R1 out_sop/eop", 32'({out_sop, out_eop}), 32'(VEC[i][18:17]));
            chk("R4 in_ready follows out_ready", 32'(in_ready), 32'(VEC[i][16]));
            chk("R4 out_valid", 32'(out_valid), 32'd1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        chk("R4 no irq while disabled", 32'(irq), 32'd0);

        // register map
        for (int k = 0; k < 3; k++) begin
            wr(4 + 2*k, 32'h100 + 32'(k));
            wr(5 + 2*k, 32'hA0 + 32'(k));
        end
        wr(1, 32'd12);
        rd_chk("R9 count clamp", 1, 32'(ENTRIES));
        wr(1, 32'd3);
        rd_chk("R9 count", 1, 32'd3);
        rd_chk("R9 entry1 address", 6, 32'h101);
        rd_chk("R9 entry2 data", 9, 32'hA2);
        rd_chk("R9 enable reset", 0, 32'd0);
        wr(0, 32'd1);
        rd_chk("R9 enable set", 0, 32'd1);

        // video trigger with three entries and stretched waits
        @(posedge clk); #1;
        m_waitrequest = 1'b1;
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_data = 16'h0000;
        @(negedge clk);
        chk("R2 in_ready held", 32'(in_ready), 32'd0);
        chk("R2 out_valid held", 32'(out_valid), 32'd0);
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < 3; w++) begin
                @(posedge clk); #1;
                m_waitrequest = (w != 2);
                @(negedge clk);
                chk("R5 m_write", 32'(m_write), 32'd1);
                chk("R5 address order", m_address, 32'h100 + 32'(k));
                chk("R5 data order", m_writedata, 32'hA0 + 32'(k));
                chk("R5 stream held", 32'(out_valid), 32'd0);
            end
        end
        @(posedge clk); #1;
        m_waitrequest = 1'b0;
        @(negedge clk);
        chk("R6 beat offered", 32'(out_valid), 32'd1);
        chk("R6 header on output", 32'(out_sop), 32'd1);
        chk("R6 no further write", 32'(m_write), 32'd0);
        chk("R7 irq set", 32'(irq), 32'd1);
        @(posedge clk); #1;
        in_sop = 1'b0; in_eop = 1'b1; in_data = 16'h1234;
        @(negedge clk);
        chk("R6 following beat flows", 32'(out_valid), 32'd1);
        @(posedge clk); #1;
        in_valid = 1'b0; in_eop = 1'b0;

        wr(2, 32'd0);
        chk("R7 write 0 keeps irq", 32'(irq), 32'd1);
        wr(2, 32'd1);
        chk("R7 write 1 clears irq", 32'(irq), 32'd0);

        // control packets
        wr(1, 32'd1);
        send_ctrl(16'd640, 16'd480, 1'b1);
        send_ctrl(16'd640, 16'd480, 1'b0);
        send_ctrl(16'd640, 16'd720, 1'b1);
        send_ctrl(16'd800, 16'd720, 1'b1);
        wr(0, 32'd0);
        send_ctrl(16'd320, 16'd240, 1'b0); // R4: disabled, size still tracked
        wr(0, 32'd1);
        send_ctrl(16'd320, 16'd240, 1'b0);

        // zero-length list
        wr(2, 32'd1);
        wr(1, 32'd0);
        beat(1'b1, 1'b0, 16'h0000);
        chk("R8 detection cycle held", 32'(in_ready), 32'd0);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R8 released next cycle", 32'(out_valid), 32'd1);
        chk("R8 no master write", 32'(m_write), 32'd0);
        chk("R8 irq set", 32'(irq), 32'd1);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule